// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A watchdog timer that counts clock cycles in a free-running binary counter. When the count reaches the selected interval, the block raises a single-cycle output and the count starts again from zero. Software programs the watchdog through a small synchronous register port made of a byte-wide mode register and a write-only command register. The mode register selects one of four intervals, chooses whether an expiry requests a system reset or only signals an event, and holds the enable bit.

A stray program should not be able to switch the timer off. Stopping it therefore takes two deliberate steps. The enable bit is cleared first, and a halt key byte is then written to the command register. A separate kick key byte restarts the count, and the halt key zeroes the count as well. Only a write of 1 to the enable bit in the mode register starts a stopped watchdog again. The count is also zeroed when the interval selection changes, so that a shorter interval cannot expire at once.

The intervals are powers of two taken from counter taps. Bit `BASE_TAP + TAP_STEP*s` sets the length for selection `s`. With the defaults these are 2^15, 2^17, 2^19 and 2^21 cycles. A two-flop synchronizer asserts the internal reset at once and releases it on the clock.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the mode register reads 0x80: enable bit (bit 7) = 1, reset-on-expiry bit (bit 2) = 0, interval field (bits 1:0) = 00. The command register (address 1) always reads 0x00.
- R2: Once the count is zeroed while the watchdog runs, the expiry pulse appears 2^(BASE_TAP + TAP_STEP*sel) cycles later. Here sel is the interval field.
- R3: At expiry, `wdt_rst_req` is high for one cycle when the reset-on-expiry bit is 1, and otherwise `wdt_expired` is high for one cycle. The two are never high together. The count is zero in the pulse cycle and counting continues.
- R4: Clearing the enable bit without a later halt key leaves the watchdog counting and expiring.
- R5: A command write of 0xB1 while the enable bit is 0 stops the watchdog. It then produces no pulse until re-enabled.
- R6: A command write of 0xB1 while the enable bit is 1 zeroes the count but does not stop the watchdog.
- R7: A command write of 0x4E zeroes the count, and counting resumes from zero.
- R8: A command write of any value other than 0xB1 or 0x4E has no effect on the count or the run state.
- R9: A stopped watchdog resumes only on a mode-register write (address 0) with bit 7 = 1, counting from zero. No command write restarts it.
- R10: A mode write that changes the interval field zeroes the count. A mode write that keeps the field does not.
- R11: A zeroing write (halt key, kick key or interval change) in the cycle an expiry would occur suppresses that pulse.
- R12: The mode register reads back bits 7, 2 and 1:0 as written, and bits 6:3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 mode, 1 command |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for the selected register |
| wdt_rst_req | output | 1 | One-cycle system reset request on expiry |
| wdt_expired | output | 1 | One-cycle expiry event when reset requests are off |

## Verification
The assertions assume that the register port is synchronous to `clk`, that `bus_wr` and `bus_addr` have known values after reset, and that at most one register write occurs per cycle. They also assume that the shortest interval is longer than one cycle, so that two pulses cannot follow each other. The stimulus drives every bus input at the falling edge and holds it for a full cycle. The bench shrinks the taps so that the intervals stay at a few dozen to about a thousand cycles. Random writes choose interval codes in the short half most of the time, so that expiries, halts and re-enables all occur many times within the run.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int SEL_W = 2;
  localparam int NSEL  = 1 << SEL_W;

  localparam logic [7:0] KEY_HALT = 8'hB1;
  localparam logic [7:0] KEY_KICK = 8'h4E;

  localparam int EN_POS    = 7;
  localparam int RSTEN_POS = 2;

  typedef enum logic {
    REG_MODE = 1'b0,
    REG_CMD  = 1'b1
  } wdt_reg_e;

  typedef struct packed {
    logic             en;
    logic             rst_en;
    logic [SEL_W-1:0] sel;
  } wdt_mode_t;

  localparam wdt_mode_t MODE_RST = '{en: 1'b1, rst_en: 1'b0, sel: '0};

  function automatic logic [7:0] mode_to_byte(input wdt_mode_t m);
    logic [7:0] b;
    b            = '0;
    b[EN_POS]    = m.en;
    b[RSTEN_POS] = m.rst_en;
    b[SEL_W-1:0] = m.sel;
    return b;
  endfunction

  function automatic wdt_mode_t byte_to_mode(input logic [7:0] b);
    wdt_mode_t m;
    m.en     = b[EN_POS];
    m.rst_en = b[RSTEN_POS];
    m.sel    = b[SEL_W-1:0];
    return m;
  endfunction
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import keyed_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output wdt_mode_t  mode_q,
  output logic       run_q,
  output logic       cnt_clr
);
  wdt_mode_t mode_d;
  logic      run_d;
  logic      mode_wr, cmd_wr, mode_ce, run_ce;
  wdt_mode_t wr_mode;

  assign mode_wr = bus_wr && (wdt_reg_e'(bus_addr) == REG_MODE);
  assign cmd_wr  = bus_wr && (wdt_reg_e'(bus_addr) == REG_CMD);
  assign wr_mode = byte_to_mode(bus_wdata);

  // next state
  always_comb begin
    mode_d  = mode_q;
    run_d   = run_q;
    cnt_clr = 1'b0;
    if (mode_wr) begin
      mode_d = wr_mode;
      if (wr_mode.sel != mode_q.sel) cnt_clr = 1'b1;
      if (wr_mode.en) run_d = 1'b1;
    end
    if (cmd_wr) begin
      if (bus_wdata == KEY_HALT) begin
        cnt_clr = 1'b1;
        if (!mode_q.en) run_d = 1'b0;
      end else if (bus_wdata == KEY_KICK) begin
        cnt_clr = 1'b1;
      end
    end
  end

  assign mode_ce = mode_wr;
  assign run_ce  = mode_wr || cmd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
    end else if (mode_ce) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
    end else if (run_ce) begin
      run_q <= run_d;
    end
  end

  // read mux: command register is write-only
  always_comb begin
    if (wdt_reg_e'(bus_addr) == REG_MODE) bus_rdata = mode_to_byte(mode_q);
    else                                  bus_rdata = 8'h00;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_TAP = 15,
  parameter int TAP_STEP = 2,
  localparam int CNT_W   = BASE_TAP + TAP_STEP * (NSEL - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic [NSEL-1:0]  tap_hit;
  logic             cnt_ce;

  // one terminal-count detector per interval tap
  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    localparam int TAP = BASE_TAP + TAP_STEP * i;
    assign tap_hit[i] = &cnt_q[TAP-1:0];
  end

  assign expire = run && !clr && tap_hit[sel];
  assign cnt_ce = run || clr;

  always_comb begin
    if (clr || expire) cnt_d = '0;
    else               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rst_en,
  output logic rst_req_q,
  output logic evt_q
);
  logic rst_req_d, evt_d;

  always_comb begin
    rst_req_d = expire && rst_en;
    evt_d     = expire && !rst_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      rst_req_q <= rst_req_d;
      evt_q     <= evt_d;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_TAP = 15,
  parameter int TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst_req,
  output logic       wdt_expired
);
  localparam int CNT_W = BASE_TAP + TAP_STEP * (NSEL - 1);

  logic             rst_sync_n;
  wdt_mode_t        mode_q;
  logic             run_q;
  logic             cnt_clr;
  logic             expire;
  logic [CNT_W-1:0] cnt_q;

  wdt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .run_q     (run_q),
    .cnt_clr   (cnt_clr)
  );

  wdt_counter #(
    .BASE_TAP (BASE_TAP),
    .TAP_STEP (TAP_STEP)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (run_q),
    .clr    (cnt_clr),
    .sel    (mode_q.sel),
    .expire (expire),
    .cnt_q  (cnt_q)
  );

  wdt_event u_event (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .expire    (expire),
    .rst_en    (mode_q.rst_en),
    .rst_req_q (wdt_rst_req),
    .evt_q     (wdt_expired)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             bus_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_wdata,
  input wdt_mode_t        mode_q,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wdt_rst_req,
  input logic             wdt_expired
);
  logic cmd_wr, mode_wr;
  assign cmd_wr  = bus_wr && bus_addr;
  assign mode_wr = bus_wr && !bus_addr;

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wdt_rst_req && wdt_expired));

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wdt_rst_req |=> !wdt_rst_req);

  p_evt_single_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wdt_expired |=> !wdt_expired);

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wdt_rst_req || wdt_expired) |-> (cnt_q == '0));

  p_clear_en_keeps_run_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && !(cmd_wr && bus_wdata == KEY_HALT)) |=> run_q);

  p_halt_stops_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && bus_wdata == KEY_HALT && !mode_q.en) |=> !run_q);

  p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_q |=> !(wdt_rst_req || wdt_expired));

  p_key_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && (bus_wdata == KEY_KICK || bus_wdata == KEY_HALT)) |=> (cnt_q == '0));

  p_cmd_no_wake_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_q && !(mode_wr && bus_wdata[EN_POS])) |=> !run_q);

  p_sel_zero_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_wr && bus_wdata[SEL_W-1:0] != mode_q.sel) |=> (cnt_q == '0));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .mode_q      (mode_q),
  .run_q       (run_q),
  .cnt_q       (cnt_q),
  .wdt_rst_req (wdt_rst_req),
  .wdt_expired (wdt_expired)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int BT = 4;
  localparam int TS = 2;

  logic       clk;
  logic       rst_n;
  logic       bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       wdt_rst_req;
  logic       wdt_expired;

  keyed_wdt #(.BASE_TAP(BT), .TAP_STEP(TS)) u_keyed_wdt (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_rst_req (wdt_rst_req),
    .wdt_expired (wdt_expired)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state (post-edge values)
  int         m_cnt = 0;
  logic [1:0] m_sel = 2'b00;
  bit         m_en  = 1;
  bit         m_re  = 0;
  bit         m_run = 1;
  bit         m_rq  = 0;
  bit         m_ev  = 0;

  function automatic int period(input logic [1:0] s);
    return 1 << (BT + TS * int'(s));
  endfunction

  function automatic logic [7:0] mode_byte();
    return {m_en, 4'b0000, m_re, m_sel};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step(input bit wr, input bit a, input logic [7:0] d);
    bit clr, exp_now, run_nx;
    clr    = 0;
    run_nx = m_run;
    if (wr && !a) begin
      if (d[1:0] != m_sel) clr = 1;
      if (d[7]) run_nx = 1;
    end
    if (wr && a) begin
      if (d == 8'hB1) begin clr = 1; if (!m_en) run_nx = 0; end
      else if (d == 8'h4E) clr = 1;
    end
    exp_now = m_run && !clr && (m_cnt == period(m_sel) - 1);
    m_rq = exp_now && m_re;
    m_ev = exp_now && !m_re;
    if (clr || exp_now) m_cnt = 0;
    else if (m_run)     m_cnt = m_cnt + 1;
    if (wr && !a) begin
      m_en = d[7]; m_re = d[2]; m_sel = d[1:0];
    end
    m_run = run_nx;
  endtask

  // one cycle: compare pulses, drive, advance model, move to next falling edge
  task automatic step(input bit wr, input bit a, input logic [7:0] d, input string tag);
    chk({tag, " pulses"}, {30'd0, wdt_rst_req, wdt_expired}, {30'd0, m_rq, m_ev});
    bus_wr    = wr;
    bus_addr  = a;
    bus_wdata = d;
    model_step(wr, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input bit a, input logic [7:0] exp, input string tag);
    bus_wr   = 0;
    bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), int'(exp));
  endtask

  // kick, optionally write at step k, count steps until a pulse appears
  task automatic measure(input int k, input bit ka, input logic [7:0] kd,
                         input int exp_n, input bit exp_rq, input string tag);
    int n;
    bit got_rq;
    step(1, 1, 8'h4E, tag);
    n = 0;
    got_rq = 0;
    while (n < 5000) begin
      n++;
      if (n == k) step(1, ka, kd, tag);
      else        step(0, 0, 8'h00, tag);
      if (wdt_rst_req || wdt_expired) begin
        got_rq = wdt_rst_req;
        break;
      end
    end
    chk({tag, " interval"}, n, exp_n);
    chk({tag, " kind"}, int'(got_rq), int'(exp_rq));
  endtask

  task automatic idle_quiet(input int cycles, input string tag);
    int seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      step(0, 0, 8'h00, tag);
      if (wdt_rst_req || wdt_expired) seen++;
    end
    chk({tag, " no pulse while stopped"}, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R2 actual=still running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_ret;
    seed_ret  = $urandom(32'h0005EED5);
    rst_n     = 1'b0;
    bus_addr  = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    rd(0, 8'h80, "R1 mode reset value");
    rd(1, 8'h00, "R1 command reads zero");

    // R2 / R3 default interval, event pulse
    measure(0, 0, 8'h00, 16, 0, "R2 sel0 event");
    // R10 interval change zeroes, then R2 sel1
    step(1, 0, 8'h81, "R10 select sel1");
    rd(0, 8'h81, "R12 readback sel1");
    measure(0, 0, 8'h00, 64, 0, "R2 sel1 event");
    step(1, 0, 8'h80, "R10 back to sel0");
    // R3 reset request path
    step(1, 0, 8'h84, "R3 enable reset request");
    rd(0, 8'h84, "R12 readback rst_en");
    measure(0, 0, 8'h00, 16, 1, "R3 reset request");
    step(0, 0, 8'h00, "R3 pulse ends");
    step(1, 0, 8'hF8, "R12 junk bits write");
    rd(0, 8'h80, "R12 unused bits read zero");

    // R8 unknown command byte ignored
    measure(8, 1, 8'h55, 16, 0, "R8 ignored command");
    // R6 halt key while enabled only zeroes
    measure(10, 1, 8'hB1, 26, 0, "R6 halt while enabled");
    // R7 kick mid-interval
    measure(5, 1, 8'h4E, 21, 0, "R7 kick restarts");
    // R10 same select keeps count, changed select zeroes
    measure(10, 0, 8'h80, 16, 0, "R10 same select");
    measure(10, 0, 8'h81, 74, 0, "R10 changed select");
    step(1, 0, 8'h80, "R10 restore sel0");
    // R11 kick exactly in the expiry cycle
    measure(16, 1, 8'h4E, 32, 0, "R11 kick at expiry");

    // R4 enable bit cleared alone keeps running
    step(1, 0, 8'h00, "R4 clear enable");
    rd(0, 8'h00, "R12 readback disabled");
    measure(0, 0, 8'h00, 16, 0, "R4 still expires");
    // R5 halt key after clearing stops it
    step(1, 1, 8'hB1, "R5 halt");
    idle_quiet(300, "R5");
    // R9 command writes never restart
    step(1, 1, 8'h4E, "R9 kick while stopped");
    step(1, 1, 8'h80, "R9 odd byte while stopped");
    idle_quiet(100, "R9");
    step(1, 0, 8'h80, "R9 re-enable");
    begin
      int n;
      n = 0;
      while (n < 100 && !(wdt_rst_req || wdt_expired)) begin
        step(0, 0, 8'h00, "R9 resumed");
        n++;
      end
      chk("R9 interval after re-enable", n, 16);
    end

    // random mix against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom % 64);
      if (r < 3) begin
        case ($urandom % 4)
          0:       d = 8'hB1;
          1:       d = 8'h4E;
          default: d = 8'($urandom);
        endcase
        step(1, 1, d, "R3 random command");
      end else if (r < 6) begin
        d = 8'($urandom);
        d[7] = (($urandom % 4) != 0);
        d[1:0] = (($urandom % 4) == 0) ? 2'b01 : 2'b00;
        step(1, 0, d, "R3 random mode");
        rd(0, mode_byte(), "R12 random readback");
      end else begin
        step(0, 0, 8'h00, "R3 random idle");
      end
    end
    rd(1, 8'h00, "R1 command still zero");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule